// File: doc/BRIEF.md
# Throttled Byte Stream Source

This block is an AXI4-Stream transmitter that emits one packet of sixteen bytes
from a computed pattern each time it is started. Its purpose is to exercise a
downstream sink with stalls that come from the source side. On request it
withholds tvalid between beats, either before one selected beat or before beats
picked at random. The length of each withheld stretch is either fixed or random
up to a bound. A free-running 16-bit maximal-length LFSR supplies all the random
choices.

The output side follows valid/ready rules. A beat moves only on a rising clock
edge where tvalid and tready are both high. Once tvalid is raised for a beat it
stays raised, with tdata and tlast held, until that beat is taken. Back-pressure
is therefore always honoured, and gaps only ever appear between beats. A stall
watchdog counts consecutive cycles in which the sink refuses a presented beat.
When that count passes a limit, the watchdog sets a sticky error flag. After the
final beat is taken, the block pulses done for one cycle and then waits for the
next start.

Top module: `axis_throttled_source`

## Requirements
- R1: After synchronous active-high reset, m_tvalid, m_tlast, done_o and timeout_o are all low.
- R2: A packet carries 16 beats in index order 0 to 15, and beat i carries the byte (i*17) mod 256, that is 0x00, 0x11, ... 0xFF.
- R3: m_tlast is high with beat 15 and low with every other beat. After beat 15 is taken, m_tvalid falls in the next cycle.
- R4: While m_tvalid is high and m_tready is low, m_tvalid stays high and m_tdata and m_tlast stay unchanged.
- R5: With mode 0 and m_tready held high, m_tvalid is high for exactly 16 consecutive cycles starting one cycle after start_i is sampled. done_o is high for exactly the one cycle after the last beat is taken.
- R6: In fixed mode (mode_i = 1), the only gap comes right before beat gap_beat_i, and it works for index 0 and for index 15. Mode values 0 and 3 produce no gaps.
- R7: In random mode (mode_i = 2), a gap precedes a beat when the LFSR low byte is below prob_i, or always when prob_i = 255. prob_i = 0 gives no gaps, and prob_i = 128 gives a gap chance of one half.
- R8: With len_rand_i = 0, every gap lasts gap_len_i cycles of low m_tvalid, and gap_len_i = 0 means no gap. With len_rand_i = 1, every gap lasts between 1 and gap_len_i cycles.
- R9: When m_tvalid is high and m_tready is low for more than timeout_lim_i consecutive cycles, timeout_o goes high after the edge that ends stall number timeout_lim_i+1. It then stays high until reset.
- R10: One start sends exactly one packet. A start while a packet is in progress is ignored, and after done_o m_tvalid stays low until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Pulse that begins one packet when idle |
| mode_i | input | 2 | Throttle mode: 0 off, 1 fixed beat, 2 random, 3 off |
| gap_beat_i | input | 4 | Beat index preceded by a gap in fixed mode |
| prob_i | input | 8 | Random gap threshold against the LFSR low byte |
| len_rand_i | input | 1 | 0: gap length fixed, 1: random length |
| gap_len_i | input | 4 | Fixed gap length, or maximum random length |
| timeout_lim_i | input | 16 | Allowed consecutive stalled cycles |
| m_tready | input | 1 | Sink ready |
| m_tdata | output | 8 | Beat data |
| m_tvalid | output | 1 | Beat valid |
| m_tlast | output | 1 | Final beat marker |
| done_o | output | 1 | One-cycle pulse after the last beat is taken |
| timeout_o | output | 1 | Sticky stall error flag |

## Verification
m_tvalid for beat 0 is due one cycle after start_i is sampled, or one cycle plus the gap length when a gap precedes it. Each later beat is due on the cycle after the previous beat is taken, plus that beat's gap. done_o is due one cycle after the edge that takes beat 15, and timeout_o is due one cycle after the edge that ends stall number timeout_lim_i+1. Inputs change one time unit after a rising edge and outputs are sampled on the falling edge. A falling-edge sample of m_tvalid and m_tready both high therefore marks the transfer at the next rising edge. That sample is where the scoreboard pops, and where the gap length before each beat is measured as the count of low m_tvalid samples. Cycle-exact checks of the unthrottled packet and of the watchdog count falling edges from the start edge.

// File: rtl/axis_src_pkg.sv
package axis_src_pkg;
  typedef enum logic [1:0] {
    THR_OFF    = 2'd0,
    THR_FIXED  = 2'd1,
    THR_RANDOM = 2'd2,
    THR_SPARE  = 2'd3
  } thr_mode_t;

  typedef enum logic [1:0] {
    SRC_IDLE = 2'd0,
    SRC_GAP  = 2'd1,
    SRC_SEND = 2'd2
  } src_state_t;

  localparam int unsigned RNG_W  = 16;
  localparam logic [15:0] RNG_TAPS = 16'hD008;
  localparam logic [15:0] RNG_SEED = 16'hACE1;
endpackage

// File: rtl/axis_src_lfsr.sv
module axis_src_lfsr #(
  parameter int unsigned W    = 16,
  parameter logic [W-1:0] TAPS = 16'hD008,
  parameter logic [W-1:0] SEED = 16'hACE1
) (
  input  logic         clk,
  input  logic         rst,
  output logic [W-1:0] state_o
);
  logic [W-1:0] st;
  logic         fb;

  assign fb = ^(st & TAPS);

  always_ff @(posedge clk) begin
    if (rst) st <= SEED;
    else     st <= {st[W-2:0], fb};
  end

  assign state_o = st;

  // R7: the random source never locks up at zero
  a_r7_lfsr_nonzero: assert property (@(posedge clk) disable iff (rst)
    st != '0);
endmodule

// File: rtl/axis_src_gap_plan.sv
module axis_src_gap_plan
  import axis_src_pkg::*;
#(
  parameter int unsigned IDX_W  = 4,
  parameter int unsigned PROB_W = 8,
  parameter int unsigned LEN_W  = 4,
  parameter int unsigned RND_W  = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       mode_i,
  input  logic [IDX_W-1:0] beat_i,
  input  logic [IDX_W-1:0] gap_beat_i,
  input  logic [PROB_W-1:0] prob_i,
  input  logic             len_rand_i,
  input  logic [LEN_W-1:0] gap_len_i,
  input  logic [RND_W-1:0] rnd_i,
  output logic [LEN_W-1:0] gap_cycles_o
);
  localparam int unsigned LEN_LO = PROB_W;

  logic [PROB_W-1:0] coin;
  logic [LEN_W-1:0]  pick;
  logic              hit_fixed, hit_rand;
  logic [LEN_W-1:0]  len;

  assign coin = rnd_i[PROB_W-1:0];
  assign pick = rnd_i[LEN_LO +: LEN_W];

  always_comb begin
    hit_fixed = (thr_mode_t'(mode_i) == THR_FIXED) && (beat_i == gap_beat_i);
    hit_rand  = (thr_mode_t'(mode_i) == THR_RANDOM) &&
                ((prob_i == '1) || (coin < prob_i));
    if (!len_rand_i)            len = gap_len_i;
    else if (gap_len_i == '0)   len = '0;
    else if (pick < gap_len_i)  len = pick + 1'b1;
    else                        len = gap_len_i;
    gap_cycles_o = (hit_fixed || hit_rand) ? len : '0;
  end

  // R8: a random gap never exceeds the configured maximum
  a_r8_len_bound: assert property (@(posedge clk) disable iff (rst)
    (len_rand_i && gap_cycles_o != '0) |-> (gap_cycles_o <= gap_len_i));
endmodule

// File: rtl/axis_src_stall_watch.sv
module axis_src_stall_watch #(
  parameter int unsigned TO_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            valid_i,
  input  logic            ready_i,
  input  logic [TO_W-1:0] limit_i,
  output logic            timeout_o
);
  logic [TO_W-1:0] stalls;
  logic            flag;

  always_ff @(posedge clk) begin
    if (rst) begin
      stalls <= '0;
      flag   <= 1'b0;
    end else if (valid_i && !ready_i) begin
      if (stalls == limit_i) flag   <= 1'b1;
      else                   stalls <= stalls + 1'b1;
    end else begin
      stalls <= '0;
    end
  end

  assign timeout_o = flag;

  // R9: the flag only rises at the end of a refused beat
  a_r9_rise_on_stall: assert property (@(posedge clk) disable iff (rst)
    $rose(flag) |-> $past(valid_i && !ready_i));
  // R9: once raised the flag holds until reset
  a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
    flag |=> flag);
endmodule

// File: rtl/axis_throttled_source.sv
module axis_throttled_source
  import axis_src_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned BEATS  = 16,
  parameter int unsigned PROB_W = 8,
  parameter int unsigned LEN_W  = 4,
  parameter int unsigned TO_W   = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start_i,
  input  logic [1:0]               mode_i,
  input  logic [$clog2(BEATS)-1:0] gap_beat_i,
  input  logic [PROB_W-1:0]        prob_i,
  input  logic                     len_rand_i,
  input  logic [LEN_W-1:0]         gap_len_i,
  input  logic [TO_W-1:0]          timeout_lim_i,
  input  logic                     m_tready,
  output logic [DATA_W-1:0]        m_tdata,
  output logic                     m_tvalid,
  output logic                     m_tlast,
  output logic                     done_o,
  output logic                     timeout_o
);
  localparam int unsigned IDX_W = $clog2(BEATS);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BEATS - 1);

  src_state_t       state;
  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] plan_idx;
  logic [LEN_W-1:0] gap_cnt;
  logic [LEN_W-1:0] gap_cycles;
  logic [RNG_W-1:0] rnd;
  logic             done_q;
  logic             xfer;

  function automatic logic [DATA_W-1:0] beat_byte(input logic [IDX_W-1:0] i);
    logic [DATA_W+IDX_W+4:0] p;
    p = (DATA_W+IDX_W+5)'(i) * 17;
    return p[DATA_W-1:0];
  endfunction

  axis_src_lfsr #(.W(RNG_W), .TAPS(RNG_TAPS), .SEED(RNG_SEED)) u_rng (
    .clk(clk), .rst(rst), .state_o(rnd)
  );

  assign plan_idx = (state == SRC_IDLE) ? '0 : idx + 1'b1;

  axis_src_gap_plan #(
    .IDX_W(IDX_W), .PROB_W(PROB_W), .LEN_W(LEN_W), .RND_W(RNG_W)
  ) u_plan (
    .clk(clk), .rst(rst), .mode_i(mode_i), .beat_i(plan_idx),
    .gap_beat_i(gap_beat_i), .prob_i(prob_i), .len_rand_i(len_rand_i),
    .gap_len_i(gap_len_i), .rnd_i(rnd), .gap_cycles_o(gap_cycles)
  );

  assign xfer = (state == SRC_SEND) && m_tready;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= SRC_IDLE;
      idx     <= '0;
      gap_cnt <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state)
        SRC_IDLE: begin
          if (start_i) begin
            idx     <= '0;
            gap_cnt <= gap_cycles;
            state   <= (gap_cycles != '0) ? SRC_GAP : SRC_SEND;
          end
        end
        SRC_GAP: begin
          gap_cnt <= gap_cnt - 1'b1;
          if (gap_cnt == LEN_W'(1)) state <= SRC_SEND;
        end
        SRC_SEND: begin
          if (m_tready) begin
            if (idx == LAST_IDX) begin
              state  <= SRC_IDLE;
              done_q <= 1'b1;
            end else begin
              idx     <= idx + 1'b1;
              gap_cnt <= gap_cycles;
              state   <= (gap_cycles != '0) ? SRC_GAP : SRC_SEND;
            end
          end
        end
        default: state <= SRC_IDLE;
      endcase
    end
  end

  assign m_tvalid = (state == SRC_SEND);
  assign m_tdata  = beat_byte(idx);
  assign m_tlast  = m_tvalid && (idx == LAST_IDX);
  assign done_o   = done_q;

  axis_src_stall_watch #(.TO_W(TO_W)) u_watch (
    .clk(clk), .rst(rst), .valid_i(m_tvalid), .ready_i(m_tready),
    .limit_i(timeout_lim_i), .timeout_o(timeout_o)
  );

  // R4: a refused beat is held unchanged
  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata) && $stable(m_tlast)));
  // R3: nothing follows the final beat, and done follows it
  a_r3_end_after_last: assert property (@(posedge clk) disable iff (rst)
    (m_tvalid && m_tready && m_tlast) |=> (!m_tvalid && done_o));
  // R5: done is a single-cycle pulse
  a_r5_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  // R10: without a start, an idle source stays quiet
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    (state == SRC_IDLE && !start_i) |=> !m_tvalid);
endmodule

// File: tb/axis_throttled_source_test.sv
module axis_throttled_source_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [1:0]  mode_i = 2'd0;
  logic [3:0]  gap_beat_i = 4'd0;
  logic [7:0]  prob_i = 8'd0;
  logic        len_rand_i = 1'b0;
  logic [3:0]  gap_len_i = 4'd0;
  logic [15:0] timeout_lim_i = 16'd100;
  logic        m_tready = 1'b1;
  logic [7:0]  m_tdata;
  logic        m_tvalid, m_tlast, done_o, timeout_o;

  int n_cmp = 0, n_bad = 0;
  logic [8:0] exp_q[$];
  int  gaps[16];
  int  low_run, beat_no;
  bit  active, done_seen, finished;
  int  rdy_mode = 0;
  bit  rdy_force = 1'b1;
  int  cyc = 0;

  always #4 clk = ~clk;

  axis_throttled_source uut (
    .clk(clk), .rst(rst), .start_i(start_i), .mode_i(mode_i),
    .gap_beat_i(gap_beat_i), .prob_i(prob_i), .len_rand_i(len_rand_i),
    .gap_len_i(gap_len_i), .timeout_lim_i(timeout_lim_i), .m_tready(m_tready),
    .m_tdata(m_tdata), .m_tvalid(m_tvalid), .m_tlast(m_tlast),
    .done_o(done_o), .timeout_o(timeout_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // ready driver: changes one time unit after each rising edge
  initial begin
    forever begin
      @(posedge clk); #1;
      cyc++;
      case (rdy_mode)
        0: m_tready = 1'b1;
        1: m_tready = (cyc % 3) != 2;
        default: m_tready = rdy_force;
      endcase
    end
  end

  // monitor: scoreboard pops and gap measurement
  always @(negedge clk) begin
    if (!rst) begin
      if (done_o) done_seen = 1'b1;
      if (active && !m_tvalid) low_run++;
      if (m_tvalid && m_tready) begin
        if (exp_q.size() == 0) begin
          chk(0, "R10", "unexpected beat", int'(m_tdata), -1);
        end else begin
          logic [8:0] e;
          e = exp_q.pop_front();
          chk(m_tdata == e[7:0], "R2", "beat data", int'(m_tdata), int'(e[7:0]));
          chk(m_tlast == e[8], "R3", "tlast", int'(m_tlast), int'(e[8]));
        end
        if (beat_no < 16) gaps[beat_no] = low_run;
        low_run = 0;
        beat_no++;
        if (m_tlast) active = 1'b0;
      end
    end
  end

  task automatic run_packet(input int mode, input int gb, input int prob,
                            input bit lr, input int len, input int rm,
                            input bit extra_start, input bit exact);
    @(negedge clk);
    mode_i = 2'(mode); gap_beat_i = 4'(gb); prob_i = 8'(prob);
    len_rand_i = lr; gap_len_i = 4'(len); rdy_mode = rm;
    for (int i = 0; i < 16; i++) begin
      exp_q.push_back({(i == 15), 8'((i * 17) % 256)});
      gaps[i] = -1;
    end
    low_run = 0; beat_no = 0; done_seen = 1'b0;
    start_i = 1'b1;
    @(posedge clk); #1;
    start_i = 1'b0;
    active = 1'b1;
    if (exact) begin
      // R5: 16 consecutive valid cycles, then a one-cycle done
      for (int c = 0; c < 16; c++) begin
        @(negedge clk);
        chk(m_tvalid == 1'b1, "R5", "tvalid in burst", int'(m_tvalid), 1);
        chk(done_o == 1'b0, "R5", "done early", int'(done_o), 0);
      end
      @(negedge clk);
      chk(m_tvalid == 1'b0, "R5", "tvalid after burst", int'(m_tvalid), 0);
      chk(done_o == 1'b1, "R5", "done pulse", int'(done_o), 1);
      @(negedge clk);
      chk(done_o == 1'b0, "R5", "done width", int'(done_o), 0);
    end else begin
      for (int w = 0; w < 3000 && !done_seen; w++) begin
        @(negedge clk);
        if (extra_start && beat_no == 8) begin
          start_i = 1'b1;      // R10: ignored mid-packet
          @(negedge clk);
          start_i = 1'b0;
          extra_start = 1'b0;
        end
      end
      chk(done_seen, "R5", "done seen", int'(done_seen), 1);
    end
    rdy_mode = 0;
    chk(beat_no == 16, "R2", "beat count", beat_no, 16);
    chk(exp_q.size() == 0, "R10", "leftover beats", exp_q.size(), 0);
    for (int q = 0; q < 4; q++) begin
      @(negedge clk);
      chk(m_tvalid == 1'b0, "R10", "quiet after done", int'(m_tvalid), 0);
    end
  endtask

  // kind 0: only beat a has gap b; 1: all gaps equal a; 2: all within a..b
  task automatic check_gaps(input string req, input int kind, input int a, input int b);
    for (int i = 0; i < 16; i++) begin
      int e;
      if (kind == 0) begin
        e = (i == a) ? b : 0;
        chk(gaps[i] == e, req, $sformatf("gap before beat %0d", i), gaps[i], e);
      end else if (kind == 1) begin
        chk(gaps[i] == a, req, $sformatf("gap before beat %0d", i), gaps[i], a);
      end else begin
        chk(gaps[i] >= a && gaps[i] <= b, req,
            $sformatf("gap range beat %0d", i), gaps[i], b);
      end
    end
  endtask

  initial begin
    #(8 * 200000);
    chk(0, "WDOG", "watchdog expired", 0, 1);
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(m_tvalid == 0, "R1", "tvalid after reset", int'(m_tvalid), 0);
    chk(m_tlast == 0, "R1", "tlast after reset", int'(m_tlast), 0);
    chk(done_o == 0, "R1", "done after reset", int'(done_o), 0);
    chk(timeout_o == 0, "R1", "timeout after reset", int'(timeout_o), 0);

    run_packet(0, 0, 0, 0, 0, 0, 0, 1);        // R5 unthrottled
    check_gaps("R5", 1, 0, 0);
    run_packet(1, 5, 0, 0, 3, 0, 0, 0);        // R6 mid beat
    check_gaps("R6", 0, 5, 3);
    run_packet(1, 0, 0, 0, 2, 1, 0, 0);        // R6 first beat, back-pressure
    check_gaps("R6", 0, 0, 2);
    run_packet(1, 15, 0, 0, 4, 1, 1, 0);       // R6 last beat, R10 extra start
    check_gaps("R6", 0, 15, 4);
    run_packet(1, 3, 0, 0, 0, 0, 0, 0);        // R8 zero length
    check_gaps("R8", 1, 0, 0);
    run_packet(3, 3, 255, 0, 5, 0, 0, 0);      // R6 spare mode is off
    check_gaps("R6", 1, 0, 0);
    run_packet(2, 0, 0, 0, 3, 1, 0, 0);        // R7 probability zero
    check_gaps("R7", 1, 0, 0);
    run_packet(2, 0, 255, 0, 2, 0, 0, 0);      // R7 always, R8 fixed len
    check_gaps("R7", 1, 2, 0);
    run_packet(2, 0, 255, 1, 5, 1, 0, 0);      // R8 random length
    check_gaps("R8", 2, 1, 5);
    run_packet(2, 0, 128, 0, 1, 0, 0, 0);      // R7 half chance
    check_gaps("R7", 2, 0, 1);

    // R9 / R4: stall watchdog with limit 10
    @(negedge clk);
    timeout_lim_i = 16'd10; mode_i = 2'd0; rdy_force = 1'b0; rdy_mode = 2;
    for (int i = 0; i < 16; i++) exp_q.push_back({(i == 15), 8'((i * 17) % 256)});
    beat_no = 0; low_run = 0; done_seen = 1'b0;
    @(negedge clk);
    start_i = 1'b1;
    @(posedge clk); #1;
    start_i = 1'b0; active = 1'b1;
    repeat (10) @(posedge clk);
    @(negedge clk);
    chk(m_tvalid == 1, "R4", "held during stall", int'(m_tvalid), 1);
    chk(m_tdata == 8'h00, "R4", "data held", int'(m_tdata), 0);
    chk(timeout_o == 0, "R9", "no flag at limit", int'(timeout_o), 0);
    @(posedge clk);
    @(negedge clk);
    chk(timeout_o == 1, "R9", "flag past limit", int'(timeout_o), 1);
    rdy_force = 1'b1;
    for (int w = 0; w < 200 && !done_seen; w++) @(negedge clk);
    chk(beat_no == 16, "R2", "beats after stall", beat_no, 16);
    chk(timeout_o == 1, "R9", "flag sticky", int'(timeout_o), 1);
    rdy_mode = 0;

    @(posedge clk); #1 rst = 1'b1;
    @(posedge clk); #1 rst = 1'b0;
    @(negedge clk);
    chk(timeout_o == 0, "R1", "flag cleared by reset", int'(timeout_o), 0);
    chk(m_tvalid == 0, "R1", "tvalid cleared by reset", int'(m_tvalid), 0);
    summary();
  end
endmodule